// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt request lines and merges them with a software-settable interrupt word. Each of the resulting sources is gated by an enable bit and assigned by a select bit to one of two classes. The block drives two registered processor lines: a fast interrupt for one class and a normal interrupt for the other. Software programs and inspects it through a simple 32-bit register bus with a one-cycle read latency.

For the normal class the block also resolves priority. Sixteen vector slots can each be bound to any source. A read of the vector register returns the stored handler address of the lowest-numbered slot whose source is pending, enabled and in the normal class. When no slot qualifies, the read returns a default handler address. A protection bit can restrict all register access to privileged bus cycles.

Top module: `vecirq_ctrl`

## Requirements
- R1: The raw source vector is the bitwise OR of `req_i` and the software interrupt register; it reads at offset 0x008. Read data appears on `bus_rdata_o` in the cycle after the access and is zero in cycles without an accepted read.
- R2: `fast_irq_o` is the registered OR of raw sources that are enabled and have select bit 1. It updates one cycle after its inputs. The same masked set reads at 0x004.
- R3: `irq_o` is the registered OR of raw sources that are enabled and have select bit 0. The same masked set reads at 0x000. The select register sits at 0x00C and is written whole.
- R4: A write to 0x010 ORs the data into the enable register, which reads back at 0x010. A write to 0x014 clears the enable bits that are 1 in the data and leaves the rest alone.
- R5: A write to 0x018 ORs the data into the software interrupt register, which reads back at 0x018. A write to 0x01C clears the bits that are 1 in the data.
- R6: Slot n has a handler address at 0x100+4n and a control word at 0x200+4n. In the control word, bits 4:0 hold the source number and bit 5 is the slot enable. Both read back what was written.
- R7: A read of 0x030 returns the handler address of the lowest-numbered slot that is enabled and whose source is pending, enabled and has select bit 0.
- R8: When no slot qualifies, a read of 0x030 returns the default address held at 0x034.
- R9: Bit 0 of 0x020 is the protection bit. While it is set, an access with `bus_priv_i` low reads zero and changes no state, including the protection bit itself.
- R10: An access with `bus_size_i` other than 2'b10 (word) is ignored: a write changes nothing and a read returns zero. The other encodings are 2'b00 for byte and 2'b01 for halfword.
- R11: After reset all registers, slot entries and both interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 32 | Interrupt request lines, active high |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_priv_i | input | 1 | Access is privileged |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the access |
| fast_irq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
The class logic is driven from a table of request, select and enable patterns. The patterns include a lone fast source, a lone normal source, a request that is masked off, a mixed pattern with both classes active, no request at all, and every line pending with nothing enabled. Together they separate the enable gate from the class split on both outputs and both status words. Priority is checked with two slots bound to one source, where the higher slot is disabled. Further steps add a higher-priority source, move it to the fast class, and then disable the last candidate. These show that slot order, slot enable, source class and source enable each take part, and that the default address is used when no slot qualifies. Protection and access size are checked by comparing state read back over a privileged word access before and after the rejected access.

// File: rtl/vecirq_pkg.sv
package vecirq_pkg;
  localparam int ADDR_W = 12;

  localparam logic [11:0] OFS_NSTAT   = 12'h000;
  localparam logic [11:0] OFS_FSTAT   = 12'h004;
  localparam logic [11:0] OFS_RAW     = 12'h008;
  localparam logic [11:0] OFS_SEL     = 12'h00C;
  localparam logic [11:0] OFS_ENSET   = 12'h010;
  localparam logic [11:0] OFS_ENCLR   = 12'h014;
  localparam logic [11:0] OFS_SOFT    = 12'h018;
  localparam logic [11:0] OFS_SOFTCLR = 12'h01C;
  localparam logic [11:0] OFS_PROT    = 12'h020;
  localparam logic [11:0] OFS_VEC     = 12'h030;
  localparam logic [11:0] OFS_DEFVEC  = 12'h034;

  localparam logic [3:0] PAGE_VADDR = 4'h1;
  localparam logic [3:0] PAGE_CTL   = 4'h2;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // Address falls inside a per-slot page and names an existing slot.
  function automatic logic in_page(input logic [11:0] a, input logic [3:0] page,
                                   input int nslot);
    return (a[11:8] == page) && (int'(a[7:2]) < nslot);
  endfunction
endpackage

// File: rtl/vecirq_vecmem.sv
module vecirq_vecmem #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  // One write port, one synchronous read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we) mem[widx] <= wdata;
      rdata_q <= mem[ridx];
    end
  end
endmodule

// File: rtl/vecirq_arbiter.sv
module vecirq_arbiter #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int SRCW  = $clog2(NSRC),
  parameter int SLW   = $clog2(NSLOT)
) (
  input  logic [NSRC-1:0]            cand,
  input  logic [NSLOT-1:0][SRCW-1:0] slot_src,
  input  logic [NSLOT-1:0]           slot_en,
  output logic                       win_valid,
  output logic [SLW-1:0]             win_idx
);
  logic [NSLOT-1:0] hit;

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    assign hit[n] = slot_en[n] & cand[slot_src[n]];
  end

  // Scan downward so the lowest-numbered hit is the last one assigned.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int n = NSLOT - 1; n >= 0; n--) begin
      if (hit[n]) begin
        win_valid = 1'b1;
        win_idx   = SLW'(n);
      end
    end
  end
endmodule

// File: rtl/vecirq_regs.sv
module vecirq_regs
  import vecirq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int SRCW  = $clog2(NSRC),
  parameter int SLW   = $clog2(NSLOT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DW-1:0]              wdata,
  output logic [NSRC-1:0]            en_q,
  output logic [NSRC-1:0]            sel_q,
  output logic [NSRC-1:0]            soft_q,
  output logic                       prot_q,
  output logic [DW-1:0]              defvec_q,
  output logic [NSLOT-1:0][SRCW-1:0] slot_src_q,
  output logic [NSLOT-1:0]           slot_en_q
);
  logic [ADDR_W-1:0] wa;
  logic              ctl_wr;
  logic [SLW-1:0]    ctl_idx;
  logic [NSRC-1:0]   wbits;

  assign wa      = {addr[ADDR_W-1:2], 2'b00};
  assign ctl_wr  = wr_en && in_page(addr, PAGE_CTL, NSLOT);
  assign ctl_idx = addr[SLW+1:2];
  assign wbits   = wdata[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      sel_q    <= '0;
      soft_q   <= '0;
      prot_q   <= 1'b0;
      defvec_q <= '0;
    end else if (wr_en) begin
      case (wa)
        OFS_SEL:     sel_q    <= wbits;
        OFS_ENSET:   en_q     <= en_q | wbits;
        OFS_ENCLR:   en_q     <= en_q & ~wbits;
        OFS_SOFT:    soft_q   <= soft_q | wbits;
        OFS_SOFTCLR: soft_q   <= soft_q & ~wbits;
        OFS_PROT:    prot_q   <= wdata[0];
        OFS_DEFVEC:  defvec_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_src_q <= '0;
      slot_en_q  <= '0;
    end else if (ctl_wr) begin
      slot_src_q[ctl_idx] <= wdata[SRCW-1:0];
      slot_en_q[ctl_idx]  <= wdata[SRCW];
    end
  end
endmodule

// File: rtl/vecirq_ctrl.sv
module vecirq_ctrl
  import vecirq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic              bus_priv_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              fast_irq_o,
  output logic              irq_o
);
  localparam int SRCW = $clog2(NSRC);
  localparam int SLW  = $clog2(NSLOT);

  logic [NSRC-1:0]            en_q, sel_q, soft_q;
  logic                       prot_q;
  logic [DW-1:0]              defvec_q;
  logic [NSLOT-1:0][SRCW-1:0] slot_src_q;
  logic [NSLOT-1:0]           slot_en_q;

  logic                       acc_ok, wr_ok, rd_ok;
  logic [ADDR_W-1:0]          wa;
  logic [NSRC-1:0]            raw, fast_set, norm_set;
  logic                       win_valid;
  logic [SLW-1:0]             win_idx;
  logic                       vec_we;
  logic [SLW-1:0]             mem_idx;
  logic [DW-1:0]              mem_q;
  logic [DW-1:0]              rd_val, reg_q;
  logic                       rd_mem, mem_sel_q;
  logic [SLW-1:0]             cidx;

  // Accepted access: word sized and allowed by the protection bit.
  assign acc_ok = bus_sel_i && (bus_size_i == SZ_WORD) && (!prot_q || bus_priv_i);
  assign wr_ok  = acc_ok && bus_wr_i;
  assign rd_ok  = acc_ok && !bus_wr_i;
  assign wa     = {bus_addr_i[ADDR_W-1:2], 2'b00};
  assign cidx   = bus_addr_i[SLW+1:2];

  assign raw      = req_i | soft_q;
  assign fast_set = raw & en_q & sel_q;
  assign norm_set = raw & en_q & ~sel_q;

  vecirq_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_ok),
    .addr       (bus_addr_i),
    .wdata      (bus_wdata_i),
    .en_q       (en_q),
    .sel_q      (sel_q),
    .soft_q     (soft_q),
    .prot_q     (prot_q),
    .defvec_q   (defvec_q),
    .slot_src_q (slot_src_q),
    .slot_en_q  (slot_en_q)
  );

  vecirq_arbiter #(.NSRC(NSRC), .NSLOT(NSLOT)) u_arb (
    .cand      (norm_set),
    .slot_src  (slot_src_q),
    .slot_en   (slot_en_q),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  assign vec_we = wr_ok && in_page(bus_addr_i, PAGE_VADDR, NSLOT);

  vecirq_vecmem #(.DEPTH(NSLOT), .DW(DW)) u_vmem (
    .clk     (clk),
    .rst     (rst),
    .we      (vec_we),
    .widx    (cidx),
    .wdata   (bus_wdata_i),
    .ridx    (mem_idx),
    .rdata_q (mem_q)
  );

  // Read decode: handler addresses come from the memory port, the rest from logic.
  always_comb begin
    rd_val  = '0;
    rd_mem  = 1'b0;
    mem_idx = cidx;
    if (in_page(bus_addr_i, PAGE_VADDR, NSLOT)) begin
      rd_mem = 1'b1;
    end else if (in_page(bus_addr_i, PAGE_CTL, NSLOT)) begin
      rd_val = DW'({slot_en_q[cidx], slot_src_q[cidx]});
    end else begin
      case (wa)
        OFS_NSTAT:  rd_val = DW'(norm_set);
        OFS_FSTAT:  rd_val = DW'(fast_set);
        OFS_RAW:    rd_val = DW'(raw);
        OFS_SEL:    rd_val = DW'(sel_q);
        OFS_ENSET:  rd_val = DW'(en_q);
        OFS_SOFT:   rd_val = DW'(soft_q);
        OFS_PROT:   rd_val = DW'(prot_q);
        OFS_DEFVEC: rd_val = defvec_q;
        OFS_VEC: begin
          if (win_valid) begin
            rd_mem  = 1'b1;
            mem_idx = win_idx;
          end else begin
            rd_val = defvec_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_irq_o <= 1'b0;
      irq_o      <= 1'b0;
      reg_q      <= '0;
      mem_sel_q  <= 1'b0;
    end else begin
      fast_irq_o <= |fast_set;
      irq_o      <= |norm_set;
      reg_q      <= rd_ok ? rd_val : '0;
      mem_sel_q  <= rd_ok && rd_mem;
    end
  end

  assign bus_rdata_o = mem_sel_q ? mem_q : reg_q;
endmodule

// File: rtl/vecirq_checker.sv
module vecirq_checker
  import vecirq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [1:0]        bus_size_i,
  input logic              bus_priv_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [DW-1:0]     bus_rdata_o,
  input logic              fast_irq_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   en_q,
  input logic              prot_q,
  input logic [DW-1:0]     defvec_q,
  input logic              win_valid
);
  logic ok_word;
  assign ok_word = bus_sel_i && (bus_size_i == SZ_WORD) && (!prot_q || bus_priv_i);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fast_irq_o && !irq_o && bus_rdata_o == '0)); // R11
  AST_FAST_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !fast_irq_o); // R2
  AST_NORM_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_o); // R3
  AST_ENCLR_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (ok_word && bus_wr_i && bus_addr_i[11:2] == OFS_ENCLR[11:2])
      |=> ((en_q & $past(bus_wdata_i[NSRC-1:0])) == '0)); // R4
  AST_DEFAULT_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (ok_word && !bus_wr_i && bus_addr_i[11:2] == OFS_VEC[11:2] && !win_valid)
      |=> (bus_rdata_o == $past(defvec_q))); // R8
  AST_PROT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_i && !bus_wr_i && prot_q && !bus_priv_i) |=> (bus_rdata_o == '0)); // R9
  AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_i && !bus_wr_i && bus_size_i != SZ_WORD) |=> (bus_rdata_o == '0)); // R10
endmodule

bind vecirq_ctrl vecirq_checker #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_size_i  (bus_size_i),
  .bus_priv_i  (bus_priv_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .fast_irq_o  (fast_irq_o),
  .irq_o       (irq_o),
  .en_q        (en_q),
  .prot_q      (prot_q),
  .defvec_q    (defvec_q),
  .win_valid   (win_valid)
);

// File: tb/tb_vecirq_ctrl.sv
module tb_vecirq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req_i = '0;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [1:0]  bus_size_i = 2'b10;
  logic        bus_priv_i = 1'b1;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        fast_irq_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vecirq_ctrl dut (
    .clk(clk), .rst(rst), .req_i(req_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_size_i(bus_size_i), .bus_priv_i(bus_priv_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .fast_irq_o(fast_irq_o), .irq_o(irq_o)
  );

  // Fields: request, select, enable, expected fast, expected normal.
  localparam logic [97:0] VEC_TBL [6] = '{
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1},
    {32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0},
    {32'h0001_0002, 32'h0000_0002, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {32'h0000_0000, 32'hFFFF_0000, 32'hFFFF_FFFF, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                           input logic [1:0] sz = 2'b10, input logic pv = 1'b1);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a;
    bus_wdata_i = d; bus_size_i = sz; bus_priv_i = pv;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_size_i = 2'b10; bus_priv_i = 1'b1;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d,
                          input logic [1:0] sz = 2'b10, input logic pv = 1'b1);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
    bus_size_i = sz; bus_priv_i = pv;
    @(negedge clk);
    d = bus_rdata_o;
    bus_sel_i = 1'b0; bus_size_i = 2'b10; bus_priv_i = 1'b1;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] t_req, t_sel, t_en;
    logic t_f, t_i;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11: reset state
    chk("R11 fast_irq_o after reset", 32'(fast_irq_o), 32'h0);
    chk("R11 irq_o after reset", 32'(irq_o), 32'h0);
    bus_read(12'h010, rd); chk("R11 enable after reset", rd, 32'h0);
    bus_read(12'h030, rd); chk("R11 vector after reset", rd, 32'h0);
    bus_read(12'h104, rd); chk("R11 slot address after reset", rd, 32'h0);

    // R2 / R3: table of class and mask patterns
    for (int i = 0; i < 6; i++) begin
      {t_req, t_sel, t_en, t_f, t_i} = VEC_TBL[i];
      bus_write(12'h00C, t_sel);
      bus_write(12'h014, 32'hFFFF_FFFF);
      bus_write(12'h010, t_en);
      req_i = t_req;
      settle();
      chk("R2 fast_irq_o table", 32'(fast_irq_o), 32'(t_f));
      chk("R3 irq_o table", 32'(irq_o), 32'(t_i));
      bus_read(12'h004, rd); chk("R2 fast status table", rd, t_req & t_en & t_sel);
      bus_read(12'h000, rd); chk("R3 normal status table", rd, t_req & t_en & ~t_sel);
    end

    // R4: enable set ORs, clear removes only written ones
    bus_write(12'h014, 32'hFFFF_FFFF);
    bus_write(12'h010, 32'h0000_000F);
    bus_write(12'h010, 32'h0000_00F0);
    bus_read(12'h010, rd); chk("R4 enable OR-set", rd, 32'h0000_00FF);
    bus_write(12'h014, 32'h0000_000F);
    bus_read(12'h010, rd); chk("R4 enable clear", rd, 32'h0000_00F0);

    // R5 / R1: software interrupt word and raw vector
    req_i = '0;
    bus_write(12'h018, 32'h0000_0003);
    bus_write(12'h018, 32'h0000_0004);
    bus_read(12'h008, rd); chk("R5 software OR-set seen in raw", rd, 32'h0000_0007);
    bus_write(12'h01C, 32'h0000_0005);
    bus_read(12'h018, rd); chk("R5 software clear", rd, 32'h0000_0002);
    req_i = 32'h0000_0100;
    bus_read(12'h008, rd); chk("R1 raw is request OR software", rd, 32'h0000_0102);
    bus_write(12'h01C, 32'hFFFF_FFFF);
    req_i = '0;

    // R6: slot programming and readback
    bus_write(12'h00C, 32'h0);
    bus_write(12'h010, 32'hFFFF_FFFF);
    bus_write(12'h200, 32'h0000_0009);
    bus_write(12'h100, 32'hA000_0000);
    bus_write(12'h208, 32'h0000_0024);
    bus_write(12'h108, 32'hA000_0002);
    bus_write(12'h214, 32'h0000_0029);
    bus_write(12'h114, 32'hA000_0005);
    bus_write(12'h034, 32'hDEF0_0000);
    bus_read(12'h208, rd); chk("R6 slot 2 control readback", rd, 32'h0000_0024);
    bus_read(12'h114, rd); chk("R6 slot 5 address readback", rd, 32'hA000_0005);

    // R7: priority resolution
    req_i = 32'h0000_0200;
    settle();
    bus_read(12'h030, rd); chk("R7 disabled slot 0 skipped", rd, 32'hA000_0005);
    req_i = 32'h0000_0210;
    settle();
    bus_read(12'h030, rd); chk("R7 slot 2 beats slot 5", rd, 32'hA000_0002);
    bus_write(12'h00C, 32'h0000_0010);
    settle();
    bus_read(12'h030, rd); chk("R7 fast-class source excluded", rd, 32'hA000_0005);
    chk("R2 fast line for source 4", 32'(fast_irq_o), 32'h1);

    // R8: nothing qualifies
    bus_write(12'h014, 32'h0000_0200);
    settle();
    bus_read(12'h030, rd); chk("R8 default vector", rd, 32'hDEF0_0000);
    chk("R3 normal line low with no normal source", 32'(irq_o), 32'h0);
    bus_write(12'h00C, 32'h0);
    req_i = '0;

    // R9: protection
    bus_write(12'h014, 32'hFFFF_FFFF);
    bus_write(12'h010, 32'h0000_0011);
    bus_write(12'h020, 32'h1);
    bus_write(12'h010, 32'hFFFF_FFFF, 2'b10, 1'b0);
    bus_read(12'h010, rd); chk("R9 unprivileged write blocked", rd, 32'h0000_0011);
    bus_read(12'h010, rd, 2'b10, 1'b0); chk("R9 unprivileged read zero", rd, 32'h0);
    bus_write(12'h020, 32'h0, 2'b10, 1'b0);
    bus_read(12'h020, rd); chk("R9 protection bit kept", rd, 32'h1);
    bus_write(12'h020, 32'h0);
    bus_read(12'h010, rd, 2'b10, 1'b0); chk("R9 unprotected read", rd, 32'h0000_0011);

    // R10: narrow accesses
    bus_write(12'h010, 32'h0000_FF00, 2'b01);
    bus_read(12'h010, rd); chk("R10 halfword write ignored", rd, 32'h0000_0011);
    bus_read(12'h010, rd, 2'b00); chk("R10 byte read zero", rd, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule